// File: doc/BRIEF.md
# Scaled Radix-2 Butterfly Rank

This block is one rank of a fixed-point radix-2 decimation-in-time butterfly. Each accepted beat carries two complex samples, `a` and `b`, and one complex twiddle factor `w`. The rank produces `x = a + b*w` and `y = a - b*w`. The product uses four real multiplies and is kept at full precision. It is shifted down by the rank's scaling amount plus the twiddle's fractional bits, and then rounded once. A parameter selects the rounding: floor truncation or round-half-to-even. Results that do not fit the output width wrap in two's complement. Each such event sets a sticky per-frame overflow flag. The flag is reported on the last output beat of the frame.

Data components are signed fractions with the binary point just below the sign bit. Data width and twiddle width are independent parameters. The scaling amount comes from a 2-bit configuration input. It is captured with the first beat of each frame and held for the rest of that frame. Beats move through valid/ready handshakes and carry first-of-frame and last-of-frame marks. One register stage separates the input from the output.

Top module: `bfly_rank`

## Requirements
- R1: While and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: For each accepted beat, the full-precision results are X = A·2^(TW-1) + B·W and Y = A·2^(TW-1) - B·W, computed as complex values. Re(B·W) = br·wr - bi·wi and Im(B·W) = br·wi + bi·wr.
- R3: Each component of X and Y is divided by 2^(TW-1+s), where s (0..3) is the frame's scaling amount.
- R4: s is taken from `cfg_scale` on the beat that has `in_sof` = 1. Values of `cfg_scale` on the other beats of the frame have no effect.
- R5: With `RND` = RND_TRUNC, the division rounds toward minus infinity.
- R6: With `RND` = RND_CONV, the division rounds to the nearest integer, and exact halves go to the even integer.
- R7: A rounded component outside [-2^(DW-1), 2^(DW-1)-1] is output as its low DW bits. It is wrapped, not saturated.
- R8: On a beat with `out_eof` = 1, `out_ovf` is 1 if any component of any beat from the frame's `in_sof` beat through this beat overflowed. On every other beat, `out_ovf` is 0. The flag starts over at each `in_sof` beat.
- R9: A beat is accepted on a clock edge where `in_valid` and `in_ready` are both 1, and its result is valid one cycle later. While `out_valid` = 1 and `out_ready` = 0, the outputs hold steady and `in_ready` = 0.
- R10: `out_sof` and `out_eof` equal the `in_sof` and `in_eof` of the beat being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Rank can accept a beat |
| in_sof | input | 1 | First beat of frame |
| in_eof | input | 1 | Last beat of frame |
| cfg_scale | input | 2 | Right shift for this rank, captured at frame start |
| in_a_re | input | DW | Sample a, real part |
| in_a_im | input | DW | Sample a, imaginary part |
| in_b_re | input | DW | Sample b, real part |
| in_b_im | input | DW | Sample b, imaginary part |
| in_w_re | input | TW | Twiddle, real part |
| in_w_im | input | TW | Twiddle, imaginary part |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the output beat |
| out_sof | output | 1 | First beat of frame |
| out_eof | output | 1 | Last beat of frame |
| out_x_re | output | DW | Sum output, real part |
| out_x_im | output | DW | Sum output, imaginary part |
| out_y_re | output | DW | Difference output, real part |
| out_y_im | output | DW | Difference output, imaginary part |
| out_ovf | output | 1 | Frame overflow, valid on the last beat |

## Verification
The hardest case to reach is an exact half at the rounding point, because random twiddles almost never produce one. The stimulus uses a twiddle of exactly one half with zero imaginary part and odd `b` values. This places the remainder at the half point, and it does so with both odd and even quotients. Frame overflow is forced in three places: in the middle of a frame, on a single-beat frame, and just before a clean frame. These cases show that the flag stays sticky and then starts over. The random frames are run under back-pressure, so that the stall hold and the capture of the scale mid-frame both occur.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    typedef enum logic {
        RND_TRUNC = 1'b0,
        RND_CONV  = 1'b1
    } round_mode_e;

    localparam int SCALE_W = 2;

    typedef logic [SCALE_W-1:0] scale_t;

    typedef struct packed {
        logic sof;
        logic eof;
    } mark_t;

endpackage

// File: rtl/bfly_cmul.sv
module bfly_cmul #(
    parameter int DW = 16,
    parameter int TW = 16,
    localparam int PW = DW + TW
) (
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [TW-1:0] w_re,
    input  logic signed [TW-1:0] w_im,
    output logic signed [PW:0]   p_re,
    output logic signed [PW:0]   p_im
);
    logic signed [PW-1:0] m_rr, m_ii, m_ri, m_ir;

    always_comb begin
        m_rr = PW'(b_re) * PW'(w_re);
        m_ii = PW'(b_im) * PW'(w_im);
        m_ri = PW'(b_re) * PW'(w_im);
        m_ir = PW'(b_im) * PW'(w_re);
        p_re = (PW+1)'(m_rr) - (PW+1)'(m_ii);
        p_im = (PW+1)'(m_ri) + (PW+1)'(m_ir);
    end
endmodule

// File: rtl/bfly_scale_round.sv
module bfly_scale_round #(
    parameter int DW = 16,
    parameter int TW = 16,
    parameter bfly_pkg::round_mode_e RND = bfly_pkg::RND_TRUNC,
    localparam int AW = DW + TW + 2
) (
    input  logic signed [AW-1:0]  val,
    input  bfly_pkg::scale_t      shift,
    output logic signed [DW-1:0]  res,
    output logic                  ovf
);
    int unsigned          k;
    logic signed [AW-1:0] quo;
    logic signed [AW-1:0] rnd;

    always_comb begin
        k   = (TW - 1) + int'(shift);
        quo = val >>> k;
    end

    generate
        if (RND == bfly_pkg::RND_CONV) begin : g_conv
            logic [AW-1:0] mask, half, rem;
            logic          up;
            always_comb begin
                mask = (AW'(1) << k) - AW'(1);
                half = AW'(1) << (k - 1);
                rem  = val & mask;
                up   = (rem > half) || ((rem == half) && quo[0]);
                rnd  = quo + AW'(up);
            end
        end else begin : g_trunc
            always_comb rnd = quo;
        end
    endgenerate

    always_comb begin
        res = rnd[DW-1:0];
        ovf = !((&rnd[AW-1:DW-1]) || !(|rnd[AW-1:DW-1]));
    end
endmodule

// File: rtl/bfly_frame_ovf.sv
module bfly_frame_ovf (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic sof,
    input  logic eof,
    input  logic pt_ovf,
    output logic flag
);
    logic sticky_q;
    logic sticky_d;

    always_comb begin
        sticky_d = sof ? pt_ovf : (sticky_q | pt_ovf);
        flag     = eof & sticky_d;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sticky_q <= 1'b0;
        else if (load)
            sticky_q <= sticky_d;
    end
endmodule

// File: rtl/bfly_rank.sv
module bfly_rank #(
    parameter int DW = 16,
    parameter int TW = 16,
    parameter bfly_pkg::round_mode_e RND = bfly_pkg::RND_TRUNC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_sof,
    input  logic                 in_eof,
    input  logic [1:0]           cfg_scale,
    input  logic signed [DW-1:0] in_a_re,
    input  logic signed [DW-1:0] in_a_im,
    input  logic signed [DW-1:0] in_b_re,
    input  logic signed [DW-1:0] in_b_im,
    input  logic signed [TW-1:0] in_w_re,
    input  logic signed [TW-1:0] in_w_im,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic                 out_sof,
    output logic                 out_eof,
    output logic signed [DW-1:0] out_x_re,
    output logic signed [DW-1:0] out_x_im,
    output logic signed [DW-1:0] out_y_re,
    output logic signed [DW-1:0] out_y_im,
    output logic                 out_ovf
);
    import bfly_pkg::*;

    localparam int PW    = DW + TW;
    localparam int AW    = DW + TW + 2;
    localparam int NCOMP = 4;

    logic                 take;
    scale_t               scale_q;
    scale_t               scale_eff;
    logic signed [PW:0]   p_re, p_im;
    logic signed [AW-1:0] a_re_al, a_im_al;
    logic signed [AW-1:0] full [NCOMP];
    logic signed [DW-1:0] rnd  [NCOMP];
    logic [NCOMP-1:0]     comp_ovf;
    logic                 frame_flag;
    mark_t                mark_in;

    always_comb begin
        in_ready  = !out_valid || out_ready;
        take      = in_valid && in_ready;
        scale_eff = in_sof ? scale_t'(cfg_scale) : scale_q;
        mark_in   = '{sof: in_sof, eof: in_eof};
    end

    always_ff @(posedge clk) begin
        if (rst)
            scale_q <= '0;
        else if (take && in_sof)
            scale_q <= scale_t'(cfg_scale);
    end

    bfly_cmul #(.DW(DW), .TW(TW)) u_cmul (
        .b_re (in_b_re),
        .b_im (in_b_im),
        .w_re (in_w_re),
        .w_im (in_w_im),
        .p_re (p_re),
        .p_im (p_im)
    );

    always_comb begin
        a_re_al = AW'(in_a_re) <<< (TW - 1);
        a_im_al = AW'(in_a_im) <<< (TW - 1);
        full[0] = a_re_al + AW'(p_re);
        full[1] = a_im_al + AW'(p_im);
        full[2] = a_re_al - AW'(p_re);
        full[3] = a_im_al - AW'(p_im);
    end

    generate
        for (genvar gi = 0; gi < NCOMP; gi++) begin : g_round
            bfly_scale_round #(.DW(DW), .TW(TW), .RND(RND)) u_rnd (
                .val   (full[gi]),
                .shift (scale_eff),
                .res   (rnd[gi]),
                .ovf   (comp_ovf[gi])
            );
        end
    endgenerate

    bfly_frame_ovf u_fovf (
        .clk    (clk),
        .rst    (rst),
        .load   (take),
        .sof    (mark_in.sof),
        .eof    (mark_in.eof),
        .pt_ovf (|comp_ovf),
        .flag   (frame_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_x_re  <= '0;
            out_x_im  <= '0;
            out_y_re  <= '0;
            out_y_im  <= '0;
            out_ovf   <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sof  <= mark_in.sof;
                out_eof  <= mark_in.eof;
                out_x_re <= rnd[0];
                out_x_im <= rnd[1];
                out_y_re <= rnd[2];
                out_y_im <= rnd[3];
                out_ovf  <= frame_flag;
            end
        end
    end
endmodule

// File: rtl/bfly_rank_chk.sv
module bfly_rank_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          in_sof,
    input logic          in_eof,
    input logic          out_valid,
    input logic          out_ready,
    input logic          out_sof,
    input logic          out_eof,
    input logic [DW-1:0] out_x_re,
    input logic [DW-1:0] out_x_im,
    input logic [DW-1:0] out_y_re,
    input logic [DW-1:0] out_y_im,
    input logic          out_ovf
);
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q === 1'b1)
            assert_reset_idle_R1: assert (!out_valid)
                else $error("out_valid set right after reset");
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_x_re) &&
            $stable(out_x_im) && $stable(out_y_re) && $stable(out_y_im) &&
            $stable(out_sof) && $stable(out_eof) && $stable(out_ovf)))
        else $error("output changed while stalled");

    assert_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready)
        else $error("input accepted while output stalled");

    assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid)
        else $error("accepted beat did not appear");

    assert_marks_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_sof == $past(in_sof) && out_eof == $past(in_eof)))
        else $error("frame marks lost");

    assert_flag_eof_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eof) |-> !out_ovf)
        else $error("overflow flag outside last beat");
endmodule

bind bfly_rank bfly_rank_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .out_x_re  (out_x_re),
    .out_x_im  (out_x_im),
    .out_y_re  (out_y_re),
    .out_y_im  (out_y_im),
    .out_ovf   (out_ovf)
);

// File: tb/test_bfly_rank.sv
module test_bfly_rank;
    localparam int DW = 16;
    localparam int TW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic                 in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [1:0]           cfg_scale = '0;
    logic signed [DW-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic signed [TW-1:0] w_re = '0, w_im = '0;
    logic                 out_ready = 1'b1;
    logic                 rdy_t, rdy_c, ov_t, ov_c, sof_t, sof_c, eof_t, eof_c, ovf_t, ovf_c;
    logic signed [DW-1:0] xr_t, xi_t, yr_t, yi_t, xr_c, xi_c, yr_c, yi_c;

    bfly_rank #(.DW(DW), .TW(TW), .RND(bfly_pkg::RND_TRUNC)) i_bfly_rank (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_t),
        .in_sof(in_sof), .in_eof(in_eof), .cfg_scale(cfg_scale),
        .in_a_re(a_re), .in_a_im(a_im), .in_b_re(b_re), .in_b_im(b_im),
        .in_w_re(w_re), .in_w_im(w_im), .out_valid(ov_t), .out_ready(out_ready),
        .out_sof(sof_t), .out_eof(eof_t), .out_x_re(xr_t), .out_x_im(xi_t),
        .out_y_re(yr_t), .out_y_im(yi_t), .out_ovf(ovf_t));

    bfly_rank #(.DW(DW), .TW(TW), .RND(bfly_pkg::RND_CONV)) i_bfly_rank_cnv (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_c),
        .in_sof(in_sof), .in_eof(in_eof), .cfg_scale(cfg_scale),
        .in_a_re(a_re), .in_a_im(a_im), .in_b_re(b_re), .in_b_im(b_im),
        .in_w_re(w_re), .in_w_im(w_im), .out_valid(ov_c), .out_ready(out_ready),
        .out_sof(sof_c), .out_eof(eof_c), .out_x_re(xr_c), .out_x_im(xi_c),
        .out_y_re(yr_c), .out_y_im(yi_c), .out_ovf(ovf_c));

    typedef struct {
        logic [DW-1:0] t [4];
        logic [DW-1:0] c [4];
        bit sof, eof, ft, fc;
    } exp_t;

    exp_t q[$];
    int   errors = 0, checks = 0;
    int   fscale = 0;
    bit   st_t = 0, st_c = 0;
    bit   bp_en = 0;
    bit   done = 0;

    task automatic chk(bit ok, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // divide by 2^k with the selected rounding; returns the unwrapped quotient
    function automatic longint div_rnd(longint v, int k, bit conv);
        longint qq, rem, half;
        qq = v >>> k;
        if (!conv) return qq;
        rem  = v - (qq <<< k);
        half = longint'(1) <<< (k - 1);
        if (rem > half || (rem == half && qq[0])) qq = qq + 1;
        return qq;
    endfunction

    function automatic bit fits(longint v);
        return v >= -(longint'(1) <<< (DW-1)) && v <= (longint'(1) <<< (DW-1)) - 1;
    endfunction

    // reference model and comparison, away from the active edge
    logic [DW-1:0] hold_v [8];
    bit            stalled = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (stalled) begin
                chk(xr_t == hold_v[0] && yi_t == hold_v[1] && xr_c == hold_v[2] && yi_c == hold_v[3],
                    "R9 stall hold", longint'(xr_t), longint'(hold_v[0]));
            end
            stalled = ov_t && !out_ready;
            hold_v[0] = xr_t; hold_v[1] = yi_t; hold_v[2] = xr_c; hold_v[3] = yi_c;
            if (ov_t && out_ready) begin
                if (q.size() == 0) begin
                    chk(0, "R9 unexpected output beat", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(ov_c == 1'b1, "R9 rounding variants in step", longint'(ov_c), 1);
                    chk(xr_t == e.t[0], "R2 R3 R4 R5 R7 x_re trunc", longint'(xr_t), longint'($signed(e.t[0])));
                    chk(xi_t == e.t[1], "R2 R3 R4 R5 R7 x_im trunc", longint'(xi_t), longint'($signed(e.t[1])));
                    chk(yr_t == e.t[2], "R2 R3 R4 R5 R7 y_re trunc", longint'(yr_t), longint'($signed(e.t[2])));
                    chk(yi_t == e.t[3], "R2 R3 R4 R5 R7 y_im trunc", longint'(yi_t), longint'($signed(e.t[3])));
                    chk(xr_c == e.c[0], "R2 R3 R4 R6 R7 x_re conv", longint'(xr_c), longint'($signed(e.c[0])));
                    chk(xi_c == e.c[1], "R2 R3 R4 R6 R7 x_im conv", longint'(xi_c), longint'($signed(e.c[1])));
                    chk(yr_c == e.c[2], "R2 R3 R4 R6 R7 y_re conv", longint'(yr_c), longint'($signed(e.c[2])));
                    chk(yi_c == e.c[3], "R2 R3 R4 R6 R7 y_im conv", longint'(yi_c), longint'($signed(e.c[3])));
                    chk(sof_t == e.sof && sof_c == e.sof, "R10 sof", longint'(sof_t), longint'(e.sof));
                    chk(eof_t == e.eof && eof_c == e.eof, "R10 eof", longint'(eof_t), longint'(e.eof));
                    chk(ovf_t == e.ft, "R8 frame ovf trunc", longint'(ovf_t), longint'(e.ft));
                    chk(ovf_c == e.fc, "R8 frame ovf conv", longint'(ovf_c), longint'(e.fc));
                end
            end
            if (in_valid && rdy_t) begin
                exp_t   e;
                longint pr, pi, ar, ai, v [4];
                bit     pt_t, pt_c;
                int     k;
                if (in_sof) fscale = int'(cfg_scale);
                k  = TW - 1 + fscale;
                ar = longint'(a_re) <<< (TW - 1);
                ai = longint'(a_im) <<< (TW - 1);
                pr = longint'(b_re) * longint'(w_re) - longint'(b_im) * longint'(w_im);
                pi = longint'(b_re) * longint'(w_im) + longint'(b_im) * longint'(w_re);
                v[0] = ar + pr; v[1] = ai + pi; v[2] = ar - pr; v[3] = ai - pi;
                pt_t = 0; pt_c = 0;
                for (int i = 0; i < 4; i++) begin
                    longint rt, rc;
                    rt = div_rnd(v[i], k, 0);
                    rc = div_rnd(v[i], k, 1);
                    e.t[i] = rt[DW-1:0];
                    e.c[i] = rc[DW-1:0];
                    if (!fits(rt)) pt_t = 1;
                    if (!fits(rc)) pt_c = 1;
                end
                st_t = in_sof ? pt_t : (st_t | pt_t);
                st_c = in_sof ? pt_c : (st_c | pt_c);
                e.sof = in_sof; e.eof = in_eof;
                e.ft = in_eof && st_t;
                e.fc = in_eof && st_c;
                q.push_back(e);
            end
        end
    end

    always @(posedge clk) begin
        #1;
        out_ready = bp_en ? ($urandom % 3 != 0) : 1'b1;
    end

    task automatic send(bit sof, bit eof, int sc, int ar, int ai, int br, int bi, int wr, int wi);
        in_valid = 1; in_sof = sof; in_eof = eof; cfg_scale = 2'(sc);
        a_re = DW'(ar); a_im = DW'(ai); b_re = DW'(br); b_im = DW'(bi);
        w_re = TW'(wr); w_im = TW'(wi);
        forever begin
            @(negedge clk);
            if (rdy_t) break;
        end
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(ov_t == 0 && ov_c == 0, "R1 out_valid after reset", longint'(ov_t), 0);
        chk(rdy_t == 1 && rdy_c == 1, "R1 in_ready after reset", longint'(rdy_t), 1);
        @(posedge clk); #1;

        // plain frame, scale 1
        send(1, 0, 1,  1000, -2000,  3000,  400, 23170, -23170);
        send(0, 0, 1, -5000,  1234, -7000, 2500, 32767,      0);
        send(0, 0, 1,   123,   -77,   999, -999,     0,  32767);
        send(0, 1, 1,  -300,   300,  1500, 1500, -20000, 10000);

        // exact-half ties for R6: twiddle 0.5, odd b, scale 0
        send(1, 0, 0,  10,  11,   1,   3, 16384, 0);
        send(0, 0, 0,  10,  11,   3,   1, 16384, 0);
        send(0, 0, 0, -10, -11,  -1,  -3, 16384, 0);
        send(0, 0, 0,   0,   0,   5,  -5, 16384, 0);
        send(0, 1, 0,   7,  -7,  -7,   7, 16384, 0);

        // R4: scale 2 latched at sof, later cfg_scale values ignored
        send(1, 0, 2, 20000, -20000, 20000, 20000, 30000, 5000);
        send(0, 0, 0, 20000, -20000, 20000, 20000, 30000, 5000);
        send(0, 1, 3, 20000, -20000, 20000, 20000, 30000, 5000);

        // R8: overflow in middle of frame, then a clean frame
        send(1, 0, 0,   100,   100,   100,   100, 1000, 0);
        send(0, 0, 0, 32767, 32767, 32767, 32767, 32767, 0);
        send(0, 1, 0,   100,   100,   100,   100, 1000, 0);
        send(1, 0, 0,   100,   100,   100,   100, 1000, 0);
        send(0, 1, 0,   200,   200,   200,   200, 1000, 0);
        // single-beat frame with overflow, then single clean frame
        send(1, 1, 0, -32768, -32768, 32767, 0, 32767, 0);
        send(1, 1, 0, 50, 50, 50, 50, 50, 50);

        // random frames with back-pressure and gaps
        bp_en = 1;
        for (int f = 0; f < 60; f++) begin
            int len;
            len = 1 + int'($urandom % 8);
            for (int b = 0; b < len; b++) begin
                send(b == 0, b == len - 1, int'($urandom % 4),
                     int'($urandom), int'($urandom), int'($urandom), int'($urandom),
                     int'($urandom), int'($urandom));
                if ($urandom % 4 == 0) begin
                    @(posedge clk); #1;
                end
            end
        end
        bp_en = 0;
        repeat (10) @(posedge clk);
        chk(q.size() == 0, "R9 all beats delivered", longint'(q.size()), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule